// File: doc/BRIEF.md
# Phase-Frequency Detector with Direction Control

This block compares a divided RF pulse train against a divided reference pulse train and produces pump-up and pump-down enables for a downstream charge pump. Both comparison inputs are sampled on a fast system clock. A rising edge on an input sets that input's flip-flop. When both flip-flops are set, they clear together after one clock cycle. The detector has no dead band, so a phase offset of even one clock cycle produces a correction pulse of matching width.

A direction bit reverses the sense of the loop. It exchanges which comparison input drives the up side and which drives the down side. It also exchanges which monitor output carries which divided pulse.

While the programming strobe is high, the pump enables are forced off and the flip-flops are held clear. The latched 2-bit gain code is decoded into a current-multiplier value in tenths for a current DAC. Two monitor outputs copy the comparison pulses when their enable is high and sit low otherwise.

Top module: `pfd_dirctl`

## Requirements
- R1: After synchronous reset, pump_up_o and pump_dn_o are 0, both monitor outputs are 0 and mult_o is 10.
- R2: With dir_i low, a rising edge on rf_pulse_i sets pump_up_o, and a rising edge on ref_pulse_i sets pump_dn_o. Each output goes high at the clock edge that samples the input's new high level. An input held high creates no further edge.
- R3: With dir_i high, a rising edge on rf_pulse_i sets pump_dn_o and a rising edge on ref_pulse_i sets pump_up_o.
- R4: Once pump_up_o and pump_dn_o are both high, both fall at the next clock edge, so the two never overlap for more than one cycle.
- R5: The detector has zero dead band. Rising edges sampled at the same clock edge give a one-cycle pulse on both outputs. Edges one cycle apart give the leading side a two-cycle pulse and the lagging side a one-cycle pulse.
- R6: While strobe_i is high, both pump enables are 0 and both flip-flops are cleared. Rising edges seen during the strobe are discarded, so the pump outputs stay 0 after the strobe falls until a new edge arrives.
- R7: mult_o follows gain_i one cycle later, with gain codes 00, 01, 10 and 11 mapping to 10, 15, 25 and 40 (multiplier in tenths).
- R8: With mon_en_i high, one cycle after sampling, mon_a_o carries rf_pulse_i and mon_b_o carries ref_pulse_i when dir_i is high. When dir_i is low the two are swapped.
- R9: With mon_en_i low, mon_a_o and mon_b_o are 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_pulse_i | input | 1 | Divided RF comparison pulse |
| ref_pulse_i | input | 1 | Divided reference comparison pulse |
| dir_i | input | 1 | Loop sense; swaps detector inputs and monitor outputs |
| mon_en_i | input | 1 | Monitor output enable |
| strobe_i | input | 1 | Programming strobe; disables the pump while high |
| gain_i | input | 2 | Latched pump gain code |
| pump_up_o | output | 1 | Pump-up (source) enable |
| pump_dn_o | output | 1 | Pump-down (sink) enable |
| mult_o | output | MULT_W | Current multiplier in tenths |
| mon_a_o | output | 1 | First monitor output |
| mon_b_o | output | 1 | Second monitor output |

## Verification
The bench builds the block with the default MULT_W of 6. This is the smallest width that holds the largest multiplier code, 40, so all four gain codes reach the output without truncation.

With one-bit comparison inputs, every ordering of edges is reachable within a few cycles. The random stimulus covers the following cases, each under both directions and against strobe pulses that land on every flip-flop state:
- simultaneous edges,
- edges one cycle apart,
- inputs held high across a clear.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int GAIN_W = 2;
  localparam int TENTHS_W = 8;

  // Non-binary current multipliers, expressed in tenths.
  function automatic logic [TENTHS_W-1:0] gain_tenths(input logic [GAIN_W-1:0] code);
    case (code)
      2'b00:   gain_tenths = 8'd10;
      2'b01:   gain_tenths = 8'd15;
      2'b10:   gain_tenths = 8'd25;
      default: gain_tenths = 8'd40;
    endcase
  endfunction
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= din[i];
    end
    assign rise[i] = din[i] & ~prev_q[i];
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic set_up,
  input  logic set_dn,
  output logic up_q,
  output logic dn_q
);
  logic both_set;
  assign both_set = up_q & dn_q;

  always_ff @(posedge clk) begin
    if (rst || strobe) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (both_set) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_q | set_up;
      dn_q <= dn_q | set_dn;
    end
  end
endmodule

// File: rtl/pfd_gain.sv
module pfd_gain #(
  parameter int MULT_W = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [pfd_pkg::GAIN_W-1:0] gain,
  output logic [MULT_W-1:0]          mult
);
  localparam logic [MULT_W-1:0] RESET_MULT = MULT_W'(pfd_pkg::gain_tenths(2'b00));

  always_ff @(posedge clk) begin
    if (rst) mult <= RESET_MULT;
    else     mult <= MULT_W'(pfd_pkg::gain_tenths(gain));
  end
endmodule

// File: rtl/pfd_monitor.sv
module pfd_monitor (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic dir,
  input  logic rf,
  input  logic refp,
  output logic mon_a,
  output logic mon_b
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      mon_a <= 1'b0;
      mon_b <= 1'b0;
    end else begin
      mon_a <= dir ? rf : refp;
      mon_b <= dir ? refp : rf;
    end
  end
endmodule

// File: rtl/pfd_dirctl.sv
module pfd_dirctl #(
  parameter int MULT_W = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rf_pulse_i,
  input  logic                       ref_pulse_i,
  input  logic                       dir_i,
  input  logic                       mon_en_i,
  input  logic                       strobe_i,
  input  logic [pfd_pkg::GAIN_W-1:0] gain_i,
  output logic                       pump_up_o,
  output logic                       pump_dn_o,
  output logic [MULT_W-1:0]          mult_o,
  output logic                       mon_a_o,
  output logic                       mon_b_o
);
  localparam int CH_RF  = 0;
  localparam int CH_REF = 1;
  localparam int N_CH   = 2;

  logic [N_CH-1:0] rise;
  logic set_up, set_dn, up_q, dn_q;

  pfd_edge #(.N(N_CH)) u_edge (
    .clk (clk),
    .rst (rst),
    .din ({ref_pulse_i, rf_pulse_i}),
    .rise(rise)
  );

  // Direction high: RF edge drives the sink side.
  assign set_up = dir_i ? rise[CH_REF] : rise[CH_RF];
  assign set_dn = dir_i ? rise[CH_RF]  : rise[CH_REF];

  pfd_core u_core (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe_i),
    .set_up(set_up),
    .set_dn(set_dn),
    .up_q  (up_q),
    .dn_q  (dn_q)
  );

  assign pump_up_o = up_q & ~strobe_i;
  assign pump_dn_o = dn_q & ~strobe_i;

  pfd_gain #(.MULT_W(MULT_W)) u_gain (
    .clk (clk),
    .rst (rst),
    .gain(gain_i),
    .mult(mult_o)
  );

  pfd_monitor u_mon (
    .clk  (clk),
    .rst  (rst),
    .en   (mon_en_i),
    .dir  (dir_i),
    .rf   (rf_pulse_i),
    .refp (ref_pulse_i),
    .mon_a(mon_a_o),
    .mon_b(mon_b_o)
  );
endmodule

// File: rtl/pfd_dirctl_chk.sv
module pfd_dirctl_chk #(
  parameter int MULT_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              mon_en_i,
  input logic              strobe_i,
  input logic [1:0]        gain_i,
  input logic              pump_up_o,
  input logic              pump_dn_o,
  input logic [MULT_W-1:0] mult_o,
  input logic              mon_a_o,
  input logic              mon_b_o
);
  a_r4_overlap_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (pump_up_o && pump_dn_o) |=> !(pump_up_o && pump_dn_o));

  a_r6_strobe_quiet: assert property (@(posedge clk) disable iff (rst)
    strobe_i |-> (!pump_up_o && !pump_dn_o));

  a_r7_gain_low: assert property (@(posedge clk) disable iff (rst)
    (gain_i == 2'b00) |=> (mult_o == MULT_W'(10)));

  a_r7_gain_high: assert property (@(posedge clk) disable iff (rst)
    (gain_i == 2'b11) |=> (mult_o == MULT_W'(40)));

  a_r9_mon_off: assert property (@(posedge clk) disable iff (rst)
    !mon_en_i |=> (!mon_a_o && !mon_b_o));
endmodule

bind pfd_dirctl pfd_dirctl_chk #(.MULT_W(MULT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mon_en_i (mon_en_i),
  .strobe_i (strobe_i),
  .gain_i   (gain_i),
  .pump_up_o(pump_up_o),
  .pump_dn_o(pump_dn_o),
  .mult_o   (mult_o),
  .mon_a_o  (mon_a_o),
  .mon_b_o  (mon_b_o)
);

// File: tb/pfd_dirctl_bench.sv
`timescale 1ns/1ps
module pfd_dirctl_bench;
  localparam int MULT_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rf = 1'b0, refp = 1'b0, dir = 1'b0, en = 1'b0, stb = 1'b0;
  logic [1:0] gain = 2'b00;
  logic up, dn, ma, mb;
  logic [MULT_W-1:0] mult;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference model state
  logic m_rfd = 1'b0, m_refd = 1'b0, m_up = 1'b0, m_dn = 1'b0;
  logic m_ma = 1'b0, m_mb = 1'b0;
  logic [MULT_W-1:0] m_mult = 6'd10;

  always #2.5 clk = ~clk;

  pfd_dirctl #(.MULT_W(MULT_W)) u_pfd_dirctl (
    .clk(clk), .rst(rst), .rf_pulse_i(rf), .ref_pulse_i(refp), .dir_i(dir),
    .mon_en_i(en), .strobe_i(stb), .gain_i(gain), .pump_up_o(up),
    .pump_dn_o(dn), .mult_o(mult), .mon_a_o(ma), .mon_b_o(mb)
  );

  function automatic logic [MULT_W-1:0] exp_mult(input logic [1:0] g);
    case (g)
      2'b00: return 6'd10;
      2'b01: return 6'd15;
      2'b10: return 6'd25;
      default: return 6'd40;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at negedge, advance one cycle, compare at the next negedge.
  task automatic step(input logic i_rf, input logic i_ref, input logic i_dir,
                      input logic i_en, input logic i_stb, input logic [1:0] i_g);
    logic rr, fr, a, b;
    rf = i_rf; refp = i_ref; dir = i_dir; en = i_en; stb = i_stb; gain = i_g;
    rr = i_rf & ~m_rfd;
    fr = i_ref & ~m_refd;
    a = i_dir ? fr : rr;
    b = i_dir ? rr : fr;
    if (i_stb || (m_up && m_dn)) begin
      m_up = 1'b0; m_dn = 1'b0;
    end else begin
      m_up = m_up | a; m_dn = m_dn | b;
    end
    m_ma = i_en ? (i_dir ? i_rf : i_ref) : 1'b0;
    m_mb = i_en ? (i_dir ? i_ref : i_rf) : 1'b0;
    m_mult = exp_mult(i_g);
    m_rfd = i_rf; m_refd = i_ref;
    @(posedge clk);
    @(negedge clk);
    check("R2 R3 R4 R6 pump_up", int'(up), int'(m_up & ~i_stb));
    check("R2 R3 R4 R6 pump_dn", int'(dn), int'(m_dn & ~i_stb));
    check("R7 mult", int'(mult), int'(m_mult));
    check("R8 R9 monitors", int'({ma, mb}), int'({m_ma, m_mb}));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset pump_up", int'(up), 0);
    check("R1 reset pump_dn", int'(dn), 0);
    check("R1 reset monitors", int'({ma, mb}), 0);
    check("R1 reset mult", int'(mult), 10);

    // R2: direction low
    step(1, 0, 0, 0, 0, 0); check("R2 rf edge sets up", int'({up, dn}), 2);
    step(1, 0, 0, 0, 0, 0); check("R2 held level no new edge", int'({up, dn}), 2);
    step(0, 1, 0, 0, 0, 0); check("R4 both set", int'({up, dn}), 3);
    step(0, 1, 0, 0, 0, 0); check("R4 both cleared", int'({up, dn}), 0);
    step(0, 0, 0, 0, 0, 0);
    // R3: direction high
    step(1, 0, 1, 0, 0, 0); check("R3 rf edge sets dn", int'({up, dn}), 1);
    step(0, 0, 1, 0, 0, 0); check("R3 dn held", int'({up, dn}), 1);
    step(0, 1, 1, 0, 0, 0); check("R3 ref edge sets up", int'({up, dn}), 3);
    step(0, 0, 1, 0, 0, 0); check("R4 cleared", int'({up, dn}), 0);
    // R5: zero dead band
    step(1, 1, 0, 0, 0, 0); check("R5 simultaneous pulse", int'({up, dn}), 3);
    step(0, 0, 0, 0, 0, 0); check("R5 simultaneous clear", int'({up, dn}), 0);
    step(1, 0, 0, 0, 0, 0); check("R5 lead cycle 1", int'({up, dn}), 2);
    step(1, 1, 0, 0, 0, 0); check("R5 lag arrives", int'({up, dn}), 3);
    step(0, 0, 0, 0, 0, 0); check("R5 both cleared", int'({up, dn}), 0);
    // R6: strobe
    step(1, 0, 0, 0, 0, 0); check("R6 pre-strobe up", int'({up, dn}), 2);
    step(0, 0, 0, 0, 1, 0); check("R6 strobe forces off", int'({up, dn}), 0);
    step(1, 0, 0, 0, 1, 0); check("R6 edge during strobe", int'({up, dn}), 0);
    step(0, 0, 0, 0, 0, 0); check("R6 edge discarded", int'({up, dn}), 0);
    // R7: gain decode
    for (int g = 0; g < 4; g++) begin
      step(0, 0, 0, 0, 0, 2'(g));
      check("R7 gain code", int'(mult), int'(exp_mult(2'(g))));
    end
    // R8, R9: monitors
    step(1, 0, 1, 1, 0, 0); check("R8 dir high mon", int'({ma, mb}), 2);
    step(1, 0, 0, 1, 0, 0); check("R8 dir low mon swapped", int'({ma, mb}), 1);
    step(1, 1, 0, 0, 0, 0); check("R9 monitors off", int'({ma, mb}), 0);
    step(0, 0, 0, 0, 0, 0);

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      logic d;
      d = ((i / 500) % 2) == 1;
      step(($urandom % 3) == 0, ($urandom % 3) == 0, ((i % 97) == 0) ? ~d : d,
           ($urandom % 4) != 0, ($urandom % 24) == 0, 2'($urandom % 4));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule